// File: doc/BRIEF.md
# Dual-Clock Virtual UART Bridge

This block joins two UART-style register files that live in unrelated clock domains, with no serial line and no bit timing between them. A byte written to the data register on one side is pushed straight into a cross-clock FIFO and appears in the receive path of the other side. Each direction has its own FIFO, so both sides can send and receive at the same time.

Each side sees a small register window through a plain synchronous port (address, write strobe, read strobe, write data, combinational read data). The window holds a data register (write sends, read takes the oldest received byte), a FIFO control register that can flush either FIFO, a read-only line status register and a scratch register. Status bits on each side follow what the far side does: data-ready tracks bytes arriving from the far side, and the transmitter-empty bits stay low until the far side has drained everything that was sent. Every handshake between the two domains goes through Gray-coded pointers or toggle signals, each passed through a two-flop synchronizer. Each side has its own synchronous active-high reset on its own clock.

Side A is the fast side (nominally 100 MHz) and side B the slow side (up to about 33 MHz). The logic is symmetric and does not depend on which side is faster.

Top module: `vuart_bridge`

## Requirements
- R1: Bytes written at side A offset 0 are read out at side B offset 0 in the same order with none lost, including a burst of DEPTH writes on consecutive side-A cycles with no read in between.
- R2: Bytes written at side B offset 0 are read out at side A offset 0 in the same order with none lost.
- R3: Line status bit 0 (data-ready) on a side reads 1 whenever that side's receive FIFO holds a byte that has crossed over, and 0 once the FIFO has been read empty.
- R4: Line status bits 5 and 6 on the sending side read 0 from the cycle after a write to offset 0 until the far side has read out or flushed every byte, and return to 1 a few cycles of both clocks after that.
- R5: Writing offset 2 with bit 1 set flushes the receive FIFO of the writing side; its data-ready bit reads 0 right after, and the far side's bits 5 and 6 return to 1.
- R6: Writing offset 2 with bit 1 clear and bit 2 set flushes the transmit FIFO of the writing side; bytes already written are discarded, writes to offset 0 while the flush is still in flight are dropped, the far side's data-ready reads 0 and the writer's bits 5 and 6 return to 1 once the flush completes.
- R7: With DEPTH bytes pending in one direction, a further write to offset 0 is ignored and sets line status bit 1 (overrun) on the receiving side; the bit clears on the cycle after that side reads offset 5.
- R8: A read of offset 0 with an empty receive FIFO returns 0x00 and does not advance the read position, so the next byte that arrives is the next one read.
- R9: Offset 7 is a scratch register per side: a read returns the last value written on that side and changes no FIFO state or status bit.
- R10: After reset, line status on each side reads 0x60 (data-ready 0, overrun 0, bits 5 and 6 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a | input | 1 | Side A synchronous active-high reset |
| a_addr | input | 3 | Side A register offset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data (combinational from a_addr) |
| clk_b | input | 1 | Side B clock |
| rst_b | input | 1 | Side B synchronous active-high reset |
| b_addr | input | 3 | Side B register offset |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data (combinational from b_addr) |

## Verification
The bench builds the bridge with its defaults, DEPTH of 16 and DW of 8, which lets a single 17-write burst on the fast side reach both the full boundary and the overrun path. Running side A at three times the rate of side B makes back-to-back writes outrun the pointer synchronizers, so data-ready and the empty bits are observed while the crossing is still catching up. A transmit flush issued right after a burst, followed by writes inside the flush window, shows both the discard and the drop rule.

// File: rtl/vuart_pkg.sv
package vuart_pkg;

    localparam int DEF_DEPTH = 16;
    localparam int DEF_DW    = 8;
    localparam int OFF_W     = 3;

    // register offsets within one side's window
    typedef enum logic [OFF_W-1:0] {
        OFF_DATA = 3'd0,
        OFF_CTRL = 3'd2,
        OFF_STAT = 3'd5,
        OFF_SCR  = 3'd7
    } reg_off_e;

    // control register bits
    localparam int CTRL_RX_FLUSH = 1;
    localparam int CTRL_TX_FLUSH = 2;

    typedef struct packed {
        logic       rsv_hi;
        logic       tx_idle;
        logic       hold_empty;
        logic [2:0] rsv_mid;
        logic       ovrun;
        logic       rx_ready;
    } stat_t;

    function automatic stat_t make_stat(input logic rx_ready, input logic ovrun,
                                        input logic tx_empty);
        stat_t s;
        s            = '0;
        s.rx_ready   = rx_ready;
        s.ovrun      = ovrun;
        s.hold_empty = tx_empty;
        s.tx_idle    = tx_empty;
        return s;
    endfunction

endpackage

// File: rtl/vuart_sync.sv
module vuart_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/vuart_afifo.sv
module vuart_afifo #(
    parameter int DEPTH = vuart_pkg::DEF_DEPTH,
    parameter int DW    = vuart_pkg::DEF_DW
) (
    // write domain
    input  logic          wclk,
    input  logic          wrst,
    input  logic          w_push,
    input  logic [DW-1:0] w_data,
    input  logic          w_flush_req,
    output logic          w_full,
    output logic          w_empty,
    output logic          w_busy,
    // read domain
    input  logic          rclk,
    input  logic          rrst,
    input  logic          r_pop,
    input  logic          r_flush,
    output logic [DW-1:0] r_data,
    output logic          r_empty,
    output logic          r_ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];

    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0] r_gray_s, w_gray_s;
    logic          req_t, ovr_t, ack_s;
    logic          req_s, ovr_s, req_seen, ovr_seen;

    // ---------------- write domain ----------------
    vuart_sync #(.W(PW + 1)) u_sync_to_w (
        .clk (wclk), .rst (wrst),
        .d   ({r_gray, req_seen}),
        .q   ({r_gray_s, ack_s})
    );

    logic          do_push;
    logic [PW-1:0] w_bin_nx;

    assign w_busy   = (req_t != ack_s);
    assign w_full   = (w_gray == {~r_gray_s[PW-1:PW-2], r_gray_s[PW-3:0]});
    assign w_empty  = (w_gray == r_gray_s) && !w_busy;
    assign do_push  = w_push && !w_full && !w_busy;
    assign w_bin_nx = w_bin + PW'(1);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            w_bin  <= '0;
            w_gray <= '0;
            req_t  <= 1'b0;
            ovr_t  <= 1'b0;
        end else begin
            if (do_push) begin
                w_bin  <= w_bin_nx;
                w_gray <= to_gray(w_bin_nx);
            end
            if (w_flush_req && !w_busy) req_t <= ~req_t;
            if (w_push && w_full && !w_busy) ovr_t <= ~ovr_t;
        end
    end

    always_ff @(posedge wclk) begin
        if (do_push) mem[w_bin[AW-1:0]] <= w_data;
    end

    // ---------------- read domain ----------------
    vuart_sync #(.W(PW + 2)) u_sync_to_r (
        .clk (rclk), .rst (rrst),
        .d   ({w_gray, req_t, ovr_t}),
        .q   ({w_gray_s, req_s, ovr_s})
    );

    logic          flush_now, do_pop;
    logic [PW-1:0] r_bin_nx;

    assign flush_now = r_flush || (req_s != req_seen);
    assign r_empty   = (r_gray == w_gray_s);
    assign do_pop    = r_pop && !r_empty && !flush_now;
    assign r_bin_nx  = r_bin + PW'(1);
    assign r_ovr     = (ovr_s != ovr_seen);
    assign r_data    = mem[r_bin[AW-1:0]];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            r_bin    <= '0;
            r_gray   <= '0;
            req_seen <= 1'b0;
            ovr_seen <= 1'b0;
        end else begin
            req_seen <= req_s;
            ovr_seen <= ovr_s;
            if (flush_now) begin
                r_gray <= w_gray_s;
                r_bin  <= from_gray(w_gray_s);
            end else if (do_pop) begin
                r_bin  <= r_bin_nx;
                r_gray <= to_gray(r_bin_nx);
            end
        end
    end
endmodule

// File: rtl/vuart_side.sv
module vuart_side
    import vuart_pkg::*;
#(
    parameter int DW = DEF_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OFF_W-1:0] addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    // transmit FIFO (this side writes)
    output logic             tx_push,
    output logic [DW-1:0]    tx_data,
    output logic             tx_flush,
    input  logic             tx_empty,
    // receive FIFO (this side reads)
    output logic             rx_pop,
    output logic             rx_flush,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_empty,
    input  logic             rx_ovr
);
    logic [DW-1:0] scratch;
    logic          ovrun;
    stat_t         stat;

    assign tx_push  = wr && (addr == OFF_DATA);
    assign tx_data  = wdata;
    assign tx_flush = wr && (addr == OFF_CTRL) && wdata[CTRL_TX_FLUSH] && !wdata[CTRL_RX_FLUSH];
    assign rx_flush = wr && (addr == OFF_CTRL) && wdata[CTRL_RX_FLUSH];
    assign rx_pop   = rd && (addr == OFF_DATA) && !rx_empty;
    assign stat     = make_stat(!rx_empty, ovrun, tx_empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch <= '0;
            ovrun   <= 1'b0;
        end else begin
            if (wr && (addr == OFF_SCR)) scratch <= wdata;
            if (rx_ovr)                          ovrun <= 1'b1;
            else if (rd && (addr == OFF_STAT))   ovrun <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_DATA: rdata = rx_empty ? '0 : rx_data;
            OFF_STAT: rdata = DW'(stat);
            OFF_SCR:  rdata = scratch;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/vuart_bridge.sv
module vuart_bridge
    import vuart_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int DW    = DEF_DW
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic [OFF_W-1:0] a_addr,
    input  logic             a_wr,
    input  logic             a_rd,
    input  logic [DW-1:0]    a_wdata,
    output logic [DW-1:0]    a_rdata,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic [OFF_W-1:0] b_addr,
    input  logic             b_wr,
    input  logic             b_rd,
    input  logic [DW-1:0]    b_wdata,
    output logic [DW-1:0]    b_rdata
);
    // A -> B path
    logic          ab_push, ab_flush_req, ab_wfull, ab_wempty, ab_busy;
    logic          ab_pop, ab_rflush, ab_rempty, ab_ovr;
    logic [DW-1:0] ab_wdata, ab_rdata;
    // B -> A path
    logic          ba_push, ba_flush_req, ba_wfull, ba_wempty, ba_busy;
    logic          ba_pop, ba_rflush, ba_rempty, ba_ovr;
    logic [DW-1:0] ba_wdata, ba_rdata;

    vuart_afifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo_ab (
        .wclk (clk_a), .wrst (rst_a),
        .w_push (ab_push), .w_data (ab_wdata), .w_flush_req (ab_flush_req),
        .w_full (ab_wfull), .w_empty (ab_wempty), .w_busy (ab_busy),
        .rclk (clk_b), .rrst (rst_b),
        .r_pop (ab_pop), .r_flush (ab_rflush),
        .r_data (ab_rdata), .r_empty (ab_rempty), .r_ovr (ab_ovr)
    );

    vuart_afifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo_ba (
        .wclk (clk_b), .wrst (rst_b),
        .w_push (ba_push), .w_data (ba_wdata), .w_flush_req (ba_flush_req),
        .w_full (ba_wfull), .w_empty (ba_wempty), .w_busy (ba_busy),
        .rclk (clk_a), .rrst (rst_a),
        .r_pop (ba_pop), .r_flush (ba_rflush),
        .r_data (ba_rdata), .r_empty (ba_rempty), .r_ovr (ba_ovr)
    );

    vuart_side #(.DW(DW)) u_side_a (
        .clk (clk_a), .rst (rst_a),
        .addr (a_addr), .wr (a_wr), .rd (a_rd), .wdata (a_wdata), .rdata (a_rdata),
        .tx_push (ab_push), .tx_data (ab_wdata), .tx_flush (ab_flush_req), .tx_empty (ab_wempty),
        .rx_pop (ba_pop), .rx_flush (ba_rflush), .rx_data (ba_rdata),
        .rx_empty (ba_rempty), .rx_ovr (ba_ovr)
    );

    vuart_side #(.DW(DW)) u_side_b (
        .clk (clk_b), .rst (rst_b),
        .addr (b_addr), .wr (b_wr), .rd (b_rd), .wdata (b_wdata), .rdata (b_rdata),
        .tx_push (ba_push), .tx_data (ba_wdata), .tx_flush (ba_flush_req), .tx_empty (ba_wempty),
        .rx_pop (ab_pop), .rx_flush (ab_rflush), .rx_data (ab_rdata),
        .rx_empty (ab_rempty), .rx_ovr (ab_ovr)
    );
endmodule

// File: rtl/vuart_bridge_chk.sv
module vuart_bridge_chk #(
    parameter int DW = vuart_pkg::DEF_DW
) (
    input logic          clk_a,
    input logic          rst_a,
    input logic [2:0]    a_addr,
    input logic          a_wr,
    input logic          a_rd,
    input logic [DW-1:0] a_wdata,
    input logic [DW-1:0] a_rdata,
    input logic          clk_b,
    input logic          rst_b,
    input logic [2:0]    b_addr,
    input logic          b_rd,
    input logic [DW-1:0] b_rdata,
    input logic          ab_wfull,
    input logic          ab_wempty,
    input logic          ab_busy,
    input logic          ab_rempty,
    input logic          ba_rempty
);
    // R8
    empty_read_b_chk: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_rd && b_addr == 3'd0 && ab_rempty) |-> (b_rdata == '0));

    // R8
    empty_read_a_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_rd && a_addr == 3'd0 && ba_rempty) |-> (a_rdata == '0));

    // R9
    scratch_hold_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_wr && a_addr == 3'd7) |=> ((a_addr == 3'd7 && !a_wr) |-> (a_rdata == $past(a_wdata))));

    // R4
    tx_not_idle_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_wr && a_addr == 3'd0 && !ab_wfull && !ab_busy) |=> !ab_wempty);

    // R6
    flush_pending_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_wr && a_addr == 3'd2 && a_wdata[2] && !a_wdata[1] && !ab_busy) |=> ab_busy);

    // R7
    full_not_empty_chk: assert property (@(posedge clk_a) disable iff (rst_a)
        ab_wfull |-> !ab_wempty);
endmodule

bind vuart_bridge vuart_bridge_chk #(.DW(DW)) u_chk (
    .clk_a (clk_a), .rst_a (rst_a), .a_addr (a_addr), .a_wr (a_wr), .a_rd (a_rd),
    .a_wdata (a_wdata), .a_rdata (a_rdata),
    .clk_b (clk_b), .rst_b (rst_b), .b_addr (b_addr), .b_rd (b_rd), .b_rdata (b_rdata),
    .ab_wfull (ab_wfull), .ab_wempty (ab_wempty), .ab_busy (ab_busy),
    .ab_rempty (ab_rempty), .ba_rempty (ba_rempty)
);

// File: tb/vuart_bridge_tb.sv
`timescale 1ns/1ps
module vuart_bridge_tb;
    localparam int DEPTH = 16;
    localparam int DW    = 8;

    logic          clk_a = 1'b0, clk_b = 1'b0;
    logic          rst_a, rst_b;
    logic [2:0]    a_addr = '0, b_addr = '0;
    logic          a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5  clk_a = ~clk_a;   // 100 MHz fast side
    always #15 clk_b = ~clk_b;   // slow side

    vuart_bridge #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk_a (clk_a), .rst_a (rst_a), .a_addr (a_addr), .a_wr (a_wr), .a_rd (a_rd),
        .a_wdata (a_wdata), .a_rdata (a_rdata),
        .clk_b (clk_b), .rst_b (rst_b), .b_addr (b_addr), .b_wr (b_wr), .b_rd (b_rd),
        .b_wdata (b_wdata), .b_rdata (b_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // ---- side A bus ----
    task automatic a_write(input logic [2:0] ad, input logic [7:0] d);
        @(negedge clk_a);
        a_addr = ad; a_wdata = d; a_wr = 1'b1; a_rd = 1'b0;
    endtask
    task automatic a_read(input logic [2:0] ad, output logic [7:0] d);
        @(negedge clk_a);
        a_addr = ad; a_wr = 1'b0; a_rd = 1'b1;
        #1 d = a_rdata;
    endtask
    task automatic a_idle();
        @(negedge clk_a);
        a_wr = 1'b0; a_rd = 1'b0;
    endtask
    // ---- side B bus ----
    task automatic b_write(input logic [2:0] ad, input logic [7:0] d);
        @(negedge clk_b);
        b_addr = ad; b_wdata = d; b_wr = 1'b1; b_rd = 1'b0;
    endtask
    task automatic b_read(input logic [2:0] ad, output logic [7:0] d);
        @(negedge clk_b);
        b_addr = ad; b_wr = 1'b0; b_rd = 1'b1;
        #1 d = b_rdata;
    endtask
    task automatic b_idle();
        @(negedge clk_b);
        b_wr = 1'b0; b_rd = 1'b0;
    endtask
    task automatic settle();
        a_idle(); b_idle();
        repeat (8) @(negedge clk_b);
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        logic [7:0] v;
        a_read(3'd5, v); a_idle(); chk("R10 A status after reset", v, 8'h60);
        b_read(3'd5, v); b_idle(); chk("R10 B status after reset", v, 8'h60);
    endtask

    task automatic t_burst_ab();
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) a_write(3'd0, 8'h10 + 8'(i));
        a_read(3'd5, v); a_idle();
        chk("R4 A empty bits low while pending", v, 8'h00);
        settle();
        b_read(3'd5, v); chk("R3 B data-ready after burst", v, 8'h61);
        for (int i = 0; i < DEPTH; i++) begin
            b_read(3'd0, v);
            chk("R1 A->B byte order", v, 8'h10 + 8'(i));
        end
        b_read(3'd5, v); b_idle(); chk("R3 B data-ready cleared", v, 8'h60);
        settle();
        a_read(3'd5, v); a_idle(); chk("R4 A empty bits back", v, 8'h60);
    endtask

    task automatic t_burst_ba();
        logic [7:0] v;
        for (int i = 0; i < 9; i++) b_write(3'd0, 8'hC0 ^ 8'(i * 7));
        b_idle();
        settle();
        a_read(3'd5, v); chk("R3 A data-ready after burst", v, 8'h61);
        for (int i = 0; i < 9; i++) begin
            a_read(3'd0, v);
            chk("R2 B->A byte order", v, 8'hC0 ^ 8'(i * 7));
        end
        a_idle();
        settle();
        b_read(3'd5, v); b_idle(); chk("R4 B empty bits back", v, 8'h60);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        for (int i = 0; i <= DEPTH; i++) a_write(3'd0, 8'h40 + 8'(i));
        a_idle();
        settle();
        b_read(3'd5, v); chk("R7 overrun set on B", v, 8'h63);
        b_read(3'd5, v); chk("R7 overrun cleared by status read", v, 8'h61);
        for (int i = 0; i < DEPTH; i++) begin
            b_read(3'd0, v);
            chk("R7 stored bytes intact", v, 8'h40 + 8'(i));
        end
        b_read(3'd0, v); chk("R8 empty read returns zero", v, 8'h00);
        b_read(3'd5, v); b_idle(); chk("R8 empty read leaves status", v, 8'h60);
        a_write(3'd0, 8'h5A); a_idle();
        settle();
        b_read(3'd0, v); b_idle(); chk("R8 next byte after empty read", v, 8'h5A);
    endtask

    task automatic t_scratch();
        logic [7:0] v;
        a_write(3'd7, 8'hA5); b_write(3'd7, 8'h3C);
        a_idle(); b_idle();
        a_read(3'd7, v); chk("R9 A scratch", v, 8'hA5);
        a_read(3'd7, v); a_idle(); chk("R9 A scratch reread", v, 8'hA5);
        b_read(3'd7, v); b_idle(); chk("R9 B scratch", v, 8'h3C);
        settle();
        a_read(3'd5, v); a_idle(); chk("R9 A status untouched", v, 8'h60);
    endtask

    task automatic t_rx_flush();
        logic [7:0] v;
        for (int i = 0; i < 5; i++) a_write(3'd0, 8'h80 + 8'(i));
        a_idle();
        settle();
        b_read(3'd5, v); chk("R5 B data-ready before flush", v, 8'h61);
        b_write(3'd2, 8'h02);
        b_read(3'd5, v); b_idle(); chk("R5 B data-ready after rx flush", v, 8'h60);
        settle();
        a_read(3'd5, v); a_idle(); chk("R5 A empty bits after far flush", v, 8'h60);
        a_write(3'd0, 8'h11); a_idle();
        settle();
        b_read(3'd0, v); b_idle(); chk("R5 fresh byte after flush", v, 8'h11);
    endtask

    task automatic t_tx_flush();
        logic [7:0] v;
        for (int i = 0; i < 6; i++) a_write(3'd0, 8'h20 + 8'(i));
        a_write(3'd2, 8'h04);
        a_write(3'd0, 8'hEE);   // inside flush window: dropped
        a_write(3'd0, 8'hEF);   // inside flush window: dropped
        a_idle();
        settle();
        b_read(3'd5, v); b_idle(); chk("R6 B data-ready after tx flush", v, 8'h60);
        a_read(3'd5, v); a_idle(); chk("R6 A empty bits after tx flush", v, 8'h60);
        a_write(3'd0, 8'h77); a_idle();
        settle();
        b_read(3'd0, v); chk("R6 first byte after flush", v, 8'h77);
        b_read(3'd5, v); b_idle(); chk("R6 nothing else pending", v, 8'h60);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst_a = 1'b1; rst_b = 1'b1;
        repeat (4) @(negedge clk_b);
        rst_a = 1'b0; rst_b = 1'b0;
        repeat (2) @(negedge clk_b);
        t_reset();
        t_burst_ab();
        t_burst_ba();
        t_overrun();
        t_scratch();
        t_rx_flush();
        t_tx_flush();
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end
endmodule